// File: doc/BRIEF.md
# Register-Write Command Stream Packer

This block turns a sequence of register-write requests, plus event-wait and single-byte control commands, into a compact byte-oriented command stream for a small command buffer. It tracks the address and the data value it last encoded. A later write whose upper sixteen bits match a remembered value is encoded in a three-byte short form instead of a five-byte long form, and a data value equal to the remembered one is not encoded at all. The buffer itself sits outside the block; the block drives a byte-write port into it, one byte per cycle, at consecutive addresses starting from zero.

Requests arrive on a valid/ready channel with a two-bit kind field. A finish strobe closes the stream. On finish, the block pads the stream with terminator bytes to a 32-bit boundary, pulses a done flag together with the final length, and then starts a fresh stream at offset zero with its remembered values cleared. If a request or the padding does not fit in the buffer, an overflow flag is raised and nothing more is written to that stream.

Top module: `regwr_stream_packer`

## Requirements
- R1: In a fresh stream (after reset or after done), remembered address and data are both 0xFFFFFFFF. A write then emits the long data form 0xE2 followed by the four data bytes (least significant first), then the long address form 0xE0 followed by the four address bytes (least significant first).
- R2: When a write's data equals the remembered data, no data bytes are emitted, but the address form is still emitted.
- R3: When data differs from the remembered data but its bits 31:16 match, the block emits 0x42 followed by data bits 7:0 and then bits 15:8.
- R4: When address bits 31:16 match the remembered address, the block emits 0x40 followed by address bits 7:0 and then bits 15:8. This also applies when the whole address repeats.
- R5: For a write, all data bytes are emitted before any address bytes. The remembered values are updated only by writes that are actually encoded.
- R6: A wait request (kind 1) emits 0x5F, then in_data bits 7:0, then bits 15:8.
- R7: A control request (kind 2) emits the single byte in_data bits 7:0. Kind 3 is consumed with no byte emitted, no change of state, and in_ready still high on the next cycle.
- R8: Finish appends between one and four 0x7F bytes so the length becomes a multiple of 4. It then pulses done for one cycle with done_len equal to the stream length, and the next stream starts at offset 0 with both remembered values at 0xFFFFFFFF.
- R9: The block writes one byte per cycle at wr_addr 0, 1, 2, … in stream order, with exactly done_len writes per stream.
- R10: A request whose bytes would exceed DEPTH is dropped whole and raises overflow. Overflow holds in_ready low until done. A finish in that state reports the current length without padding, and so does a finish whose padding would not fit.
- R11: While reset is applied and just after it, in_ready is high and wr_en, done and overflow are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_kind | input | 2 | 0 write, 1 wait, 2 control, 3 no-op |
| in_addr | input | 32 | Register address (write) |
| in_data | input | 32 | Data value, or operand bytes for wait/control |
| finish | input | 1 | Close the stream (honoured when idle and no request accepted) |
| wr_en | output | 1 | Buffer byte write strobe |
| wr_addr | output | $clog2(DEPTH) | Buffer byte offset |
| wr_byte | output | 8 | Byte to write |
| done | output | 1 | One-cycle pulse: stream closed |
| done_len | output | $clog2(DEPTH+1) | Final stream length in bytes |
| overflow | output | 1 | Stream exceeded the buffer |

## Verification
The bench builds the block with DEPTH set to 64 rather than 512. With that value, a rejected request, a stream that ends exactly at the buffer end with no room for padding, and overflow under random traffic all occur within a few dozen requests. A narrow address and data pool makes short forms, skipped data and repeated addresses frequent.

// File: rtl/rwsp_pkg.sv
package rwsp_pkg;
  typedef enum logic [1:0] {
    K_WRITE = 2'd0,
    K_WAIT  = 2'd1,
    K_CTRL  = 2'd2,
    K_NOP   = 2'd3
  } kind_e;

  localparam logic [7:0] OP_DAT_SHORT = 8'h42;
  localparam logic [7:0] OP_DAT_LONG  = 8'hE2;
  localparam logic [7:0] OP_ADR_SHORT = 8'h40;
  localparam logic [7:0] OP_ADR_LONG  = 8'hE0;
  localparam logic [7:0] OP_WAIT      = 8'h5F;
  localparam logic [7:0] OP_PAD       = 8'h7F;

  // longest single request: long data form + long address form
  localparam int MAXB = 10;
  localparam int NW   = $clog2(MAXB + 1);
endpackage

// File: rtl/rwsp_encoder.sv
module rwsp_encoder
  import rwsp_pkg::*;
(
  input  logic [1:0]          kind,
  input  logic [31:0]         addr,
  input  logic [31:0]         data,
  input  logic [31:0]         last_addr,
  input  logic [31:0]         last_data,
  output logic [8*MAXB-1:0]   seq,
  output logic [NW-1:0]       nbytes,
  output logic                upd_addr,
  output logic                upd_data
);
  kind_e       k;
  logic [39:0] dat_b, adr_b;
  logic [NW-1:0] dat_n, adr_n;
  logic [6:0]  shamt;

  always_comb begin
    k = kind_e'(kind);
    // data part
    if (data == last_data) begin
      dat_b = '0;
      dat_n = NW'(0);
    end else if (data[31:16] == last_data[31:16]) begin
      dat_b = {16'h0, data[15:0], OP_DAT_SHORT};
      dat_n = NW'(3);
    end else begin
      dat_b = {data, OP_DAT_LONG};
      dat_n = NW'(5);
    end
    // address part
    if (addr[31:16] == last_addr[31:16]) begin
      adr_b = {16'h0, addr[15:0], OP_ADR_SHORT};
      adr_n = NW'(3);
    end else begin
      adr_b = {addr, OP_ADR_LONG};
      adr_n = NW'(5);
    end
    shamt = {dat_n[3:0], 3'b000};

    seq      = '0;
    nbytes   = '0;
    upd_addr = 1'b0;
    upd_data = 1'b0;
    case (k)
      K_WRITE: begin
        seq      = (8*MAXB)'(dat_b) | ((8*MAXB)'(adr_b) << shamt);
        nbytes   = dat_n + adr_n;
        upd_addr = 1'b1;
        upd_data = (data != last_data);
      end
      K_WAIT: begin
        seq    = (8*MAXB)'({data[15:0], OP_WAIT});
        nbytes = NW'(3);
      end
      K_CTRL: begin
        seq    = (8*MAXB)'(data[7:0]);
        nbytes = NW'(1);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rwsp_emitter.sv
module rwsp_emitter
  import rwsp_pkg::*;
#(
  parameter int DEPTH = 512
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        load,
  input  logic [8*MAXB-1:0]           load_seq,
  input  logic [NW-1:0]               load_n,
  input  logic                        restart,
  output logic                        busy,
  output logic [$clog2(DEPTH+1)-1:0]  ptr,
  output logic                        wr_en,
  output logic [$clog2(DEPTH)-1:0]    wr_addr,
  output logic [7:0]                  wr_byte
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic [8*MAXB-1:0] sh;
  logic [NW-1:0]     cnt;

  assign busy = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      cnt     <= '0;
      ptr     <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_byte <= '0;
    end else begin
      wr_en <= 1'b0;
      if (load) begin
        sh  <= load_seq;
        cnt <= load_n;
      end else if (busy) begin
        wr_en   <= 1'b1;
        wr_byte <= sh[7:0];
        wr_addr <= ptr[AW-1:0];
        ptr     <= ptr + LW'(1);
        sh      <= sh >> 8;
        cnt     <= cnt - NW'(1);
      end
      if (restart) ptr <= '0;
    end
  end
endmodule

// File: rtl/regwr_stream_packer.sv
module regwr_stream_packer
  import rwsp_pkg::*;
#(
  parameter int DEPTH = 512
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [1:0]                  in_kind,
  input  logic [31:0]                 in_addr,
  input  logic [31:0]                 in_data,
  input  logic                        finish,
  output logic                        wr_en,
  output logic [$clog2(DEPTH)-1:0]    wr_addr,
  output logic [7:0]                  wr_byte,
  output logic                        done,
  output logic [$clog2(DEPTH+1)-1:0]  done_len,
  output logic                        overflow
);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int SW = LW + 1;

  logic [31:0]       last_addr, last_data;
  logic              fin_pend;
  logic [8*MAXB-1:0] enc_seq, load_seq;
  logic [NW-1:0]     enc_n, load_n;
  logic              upd_addr, upd_data;
  logic              busy, idle, accept, fits, fin_go, pad_fits, load, restart;
  logic [LW-1:0]     ptr;
  logic [2:0]        pad_n;

  rwsp_encoder enc_i (
    .kind(in_kind), .addr(in_addr), .data(in_data),
    .last_addr(last_addr), .last_data(last_data),
    .seq(enc_seq), .nbytes(enc_n), .upd_addr(upd_addr), .upd_data(upd_data)
  );

  assign idle     = !busy && !fin_pend;
  assign in_ready = idle && !overflow;
  assign accept   = in_valid && in_ready;
  assign fits     = ({1'b0, ptr} + SW'(enc_n)) <= SW'(DEPTH);
  assign pad_n    = 3'd4 - {1'b0, ptr[1:0]};
  assign pad_fits = ({1'b0, ptr} + SW'(pad_n)) <= SW'(DEPTH);
  assign fin_go   = finish && idle && !accept;
  assign restart  = fin_pend && !busy;
  assign load     = (accept && fits) || (fin_go && !overflow && pad_fits);
  assign load_seq = fin_go ? {MAXB{OP_PAD}} : enc_seq;
  assign load_n   = fin_go ? NW'(pad_n) : enc_n;

  rwsp_emitter #(.DEPTH(DEPTH)) emit_i (
    .clk(clk), .rst(rst), .load(load), .load_seq(load_seq), .load_n(load_n),
    .restart(restart), .busy(busy), .ptr(ptr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_byte(wr_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      last_addr <= '1;
      last_data <= '1;
      overflow  <= 1'b0;
      fin_pend  <= 1'b0;
      done      <= 1'b0;
      done_len  <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        if (fits) begin
          if (upd_addr) last_addr <= in_addr;
          if (upd_data) last_data <= in_data;
        end else begin
          overflow <= 1'b1;
        end
      end
      if (fin_go) begin
        fin_pend <= 1'b1;
        if (!overflow && !pad_fits) overflow <= 1'b1;
      end
      if (restart) begin
        done      <= 1'b1;
        done_len  <= ptr;
        fin_pend  <= 1'b0;
        overflow  <= 1'b0;
        last_addr <= '1;
        last_data <= '1;
      end
    end
  end
endmodule

// File: rtl/rwsp_checker.sv
module rwsp_checker #(
  parameter int DEPTH = 512
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        in_ready,
  input logic                        wr_en,
  input logic [$clog2(DEPTH)-1:0]    wr_addr,
  input logic [7:0]                  wr_byte,
  input logic                        done,
  input logic [$clog2(DEPTH+1)-1:0]  done_len,
  input logic                        overflow
);
  initial begin
    p_depth_words_r8: assert (DEPTH % 4 == 0);
  end

  p_reset_quiet_r11: assert property (@(posedge clk)
    rst |=> (!wr_en && !done && !overflow && in_ready));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    overflow |-> (!in_ready && !wr_en));

  p_len_bound_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> (done_len <= ($clog2(DEPTH+1))'(DEPTH)));

  p_addr_step_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + 1'b1));

  p_pad_last_r8: assert property (@(posedge clk) disable iff (rst)
    (done && !$past(overflow)) |-> ($past(wr_en) && $past(wr_byte) == 8'h7F));

  p_len_aligned_r8: assert property (@(posedge clk) disable iff (rst)
    (done && !$past(overflow)) |-> (done_len[1:0] == 2'b00));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind regwr_stream_packer rwsp_checker #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .in_ready(in_ready), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_byte(wr_byte), .done(done),
  .done_len(done_len), .overflow(overflow)
);

// File: tb/regwr_stream_packer_tb.sv
module regwr_stream_packer_tb_top;
  localparam int DEPTH = 64;
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [1:0] in_kind = '0;
  logic [31:0] in_addr = '0, in_data = '0;
  logic finish = 1'b0;
  logic in_ready, wr_en, done, overflow;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_byte;
  logic [LW-1:0] done_len;

  always #4 clk = ~clk;

  regwr_stream_packer #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_addr(in_addr), .in_data(in_data), .finish(finish),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_byte(wr_byte), .done(done),
    .done_len(done_len), .overflow(overflow)
  );

  int checks = 0, fails = 0, cycles = 0;
  logic [7:0] got [DEPTH];
  int got_n = 0;
  logic [7:0] exp_b [DEPTH];
  int exp_n;
  logic [31:0] m_la, m_ld;
  bit m_ovf;

  function automatic void chk(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    cycles++;
    if (wr_en) begin
      got[wr_addr] = wr_byte;
      got_n++;
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      summary();
    end
  end

  function automatic void m_reset();
    exp_n = 0; m_la = '1; m_ld = '1; m_ovf = 0;
  endfunction

  function automatic void m_req(int kind, logic [31:0] a, logic [31:0] d);
    logic [7:0] t [10];
    int n = 0;
    if (m_ovf) return;
    if (kind == 0) begin
      if (d != m_ld) begin
        if (d[31:16] == m_ld[31:16]) begin
          t[0] = 8'h42; t[1] = d[7:0]; t[2] = d[15:8]; n = 3;
        end else begin
          t[0] = 8'hE2; t[1] = d[7:0]; t[2] = d[15:8]; t[3] = d[23:16]; t[4] = d[31:24]; n = 5;
        end
      end
      if (a[31:16] == m_la[31:16]) begin
        t[n] = 8'h40; t[n+1] = a[7:0]; t[n+2] = a[15:8]; n += 3;
      end else begin
        t[n] = 8'hE0; t[n+1] = a[7:0]; t[n+2] = a[15:8]; t[n+3] = a[23:16]; t[n+4] = a[31:24]; n += 5;
      end
    end else if (kind == 1) begin
      t[0] = 8'h5F; t[1] = d[7:0]; t[2] = d[15:8]; n = 3;
    end else if (kind == 2) begin
      t[0] = d[7:0]; n = 1;
    end
    if (exp_n + n > DEPTH) begin
      m_ovf = 1;
      return;
    end
    for (int i = 0; i < n; i++) exp_b[exp_n + i] = t[i];
    exp_n += n;
    if (kind == 0) begin
      m_la = a;
      m_ld = d;
    end
  endfunction

  function automatic void m_fin();
    int pad;
    if (m_ovf) return;
    pad = 4 - (exp_n % 4);
    if (exp_n + pad > DEPTH) begin
      m_ovf = 1;
      return;
    end
    for (int i = 0; i < pad; i++) exp_b[exp_n + i] = 8'h7F;
    exp_n += pad;
  endfunction

  task automatic send(int kind, logic [31:0] a, logic [31:0] d);
    int g = 0;
    while (!in_ready && !overflow && g < 100) begin
      @(negedge clk); g++;
    end
    if (overflow) return;
    in_valid = 1'b1; in_kind = 2'(kind); in_addr = a; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
    m_req(kind, a, d);
  endtask

  task automatic end_stream(string req);
    int g = 0;
    int bad = 0, first = -1;
    while (!in_ready && !overflow && g < 100) begin
      @(negedge clk); g++;
    end
    finish = 1'b1;
    @(negedge clk);
    finish = 1'b0;
    m_fin();
    chk(overflow == m_ovf, "R10", "overflow after finish", overflow, m_ovf);
    g = 0;
    while (!done && g < 50) begin
      @(negedge clk); g++;
    end
    chk(done, req, "done pulse seen", done, 1);
    chk(int'(done_len) == exp_n, req, "done_len", done_len, exp_n);
    chk(got_n == exp_n, "R9", "write count", got_n, exp_n);
    for (int i = 0; i < exp_n; i++)
      if (got[i] !== exp_b[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    chk(bad == 0, req, $sformatf("stream bytes (first bad at %0d)", first),
        (first < 0) ? 0 : got[first], (first < 0) ? 0 : exp_b[first]);
    got_n = 0;
    m_reset();
  endtask

  logic [31:0] ra, rd, last_sent_d;

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(in_ready == 1'b1, "R11", "in_ready in reset", in_ready, 1);
    chk(wr_en == 1'b0 && done == 1'b0 && overflow == 1'b0, "R11", "outputs idle in reset",
        {wr_en, done, overflow}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1 && !wr_en, "R11", "idle after reset", {in_ready, wr_en}, 2'b10);

    // directed stream A
    send(0, 32'h0000_1234, 32'hDEAD_BEEF);
    send(0, 32'h0000_1238, 32'hDEAD_BEEF);
    send(0, 32'h0000_1238, 32'hDEAD_0001);
    send(0, 32'h1234_0000, 32'h5566_0001);
    send(1, 32'h0, 32'h0000_0201);
    send(2, 32'h0, 32'h0000_00B0);
    send(3, 32'hFFFF_0000, 32'h0000_0099);
    chk(in_ready == 1'b1, "R7", "kind 3 leaves block ready", in_ready, 1);
    end_stream("R8");
    chk(got[0] == 8'hE2 && got[1] == 8'hEF && got[4] == 8'hDE, "R1", "long data form", {got[0], got[1], got[4]}, 24'hE2EFDE);
    chk(got[5] == 8'hE0 && got[6] == 8'h34 && got[7] == 8'h12, "R5", "address follows data", {got[5], got[6], got[7]}, 24'hE03412);
    chk(got[10] == 8'h40 && got[11] == 8'h38 && got[12] == 8'h12, "R2", "repeated data skipped", {got[10], got[11], got[12]}, 24'h403812);
    chk(got[13] == 8'h42 && got[14] == 8'h01 && got[15] == 8'h00, "R3", "short data form", {got[13], got[14], got[15]}, 24'h420100);
    chk(got[16] == 8'h40 && got[17] == 8'h38, "R4", "repeated address short form", {got[16], got[17]}, 16'h4038);
    chk(got[19] == 8'hE2 && got[24] == 8'hE0 && got[28] == 8'h12, "R1", "upper-half change long forms", {got[19], got[24], got[28]}, 24'hE2E012);
    chk(got[29] == 8'h5F && got[30] == 8'h01 && got[31] == 8'h02, "R6", "wait bytes", {got[29], got[30], got[31]}, 24'h5F0102);
    chk(got[32] == 8'hB0 && got[33] == 8'h7F && got[35] == 8'h7F, "R7", "control byte then pad", {got[32], got[33], got[35]}, 24'hB07F7F);

    // stream B: fresh stream forgets previous values
    send(0, 32'h1234_0000, 32'h5566_0001);
    end_stream("R8");
    chk(got[0] == 8'hE2 && got[5] == 8'hE0, "R8", "restart uses long forms", {got[0], got[5]}, 16'hE2E0);

    // stream C: rejected request
    for (int i = 0; i < 6; i++) send(0, {16'(i + 16), 16'h0004}, {16'(i + 1), 16'h0000});
    send(0, 32'h7777_0000, 32'h8888_0000);
    @(negedge clk);
    chk(overflow == 1'b1 && in_ready == 1'b0, "R10", "request past end dropped", {overflow, in_ready}, 2'b10);
    end_stream("R10");

    // stream D: exactly full, padding cannot fit
    for (int i = 0; i < 6; i++) send(0, {16'(i + 32), 16'h0008}, {16'(i + 50), 16'h0000});
    for (int i = 0; i < 4; i++) send(2, 32'h0, 32'(i));
    end_stream("R10");

    // random streams
    void'($urandom(32'd20240611));
    last_sent_d = 32'h0;
    for (int s = 0; s < 30; s++) begin
      int nreq = 1 + int'($urandom % 14);
      for (int r = 0; r < nreq; r++) begin
        int sel = int'($urandom % 10);
        int ds  = int'($urandom % 4);
        case ($urandom % 3)
          0: ra[31:16] = 16'h0010;
          1: ra[31:16] = 16'h1002;
          default: ra[31:16] = 16'h6112;
        endcase
        ra[15:0] = {12'h0, 4'($urandom % 3), 2'b00};
        if (ds < 2) rd = last_sent_d;
        else if (ds == 2) rd = {last_sent_d[31:16], 16'($urandom)};
        else rd = $urandom;
        if (sel < 7) begin
          send(0, ra, rd);
          last_sent_d = rd;
        end else if (sel == 7) send(1, 32'h0, rd);
        else if (sel == 8) send(2, 32'h0, rd);
        else send(3, ra, rd);
      end
      end_stream("R8");
    end
    summary();
  end
endmodule